// File: doc/BRIEF.md
# Text-Mode Console Character Writer

This block turns a stream of byte characters into writes on a text-mode frame buffer. Each screen cell occupies two bytes: the character code at the even address and the colour attribute at the odd address just after it. The block holds a cursor row and column. It places printable characters at the cursor and reacts to carriage return and newline. When a newline arrives on the bottom row, the block moves every row up by one by copying memory. It then blanks the bottom row.

A host can also ask for a whole-screen clear and can load the cursor position directly. The frame buffer sits behind a plain synchronous byte memory with separate read and write ports, and read data returns one clock after the read request. While a scroll or a clear is running, the character input is held off through its ready signal.

Top module: `txtcon_writer`

## Requirements
- R1: A printable character at cursor (row, col) is written to byte address row*2*COLS + 2*col (160-byte row stride for 80 columns). The attribute byte at the next odd address is not written, and the column then advances by one.
- R2: Byte 0x0D sets the column to 0, keeps the row and writes no memory.
- R3: Byte 0x0A sets the column to 0 and increments the row when the row is below ROWS-1. ROWS equals SCAN_LINES/CHAR_H, which is 25 for the defaults 400/16.
- R4: Byte 0x0A on a row of ROWS-1 or more starts a scroll. Every byte at address a, for 2*COLS <= a < ROWS*2*COLS, is copied to a-2*COLS, including the attribute bytes. The row stays as it was and the column becomes 0.
- R5: After the copy, each character byte of the bottom row (even addresses from (ROWS-1)*2*COLS) is written with 0x20. The bottom row's attribute bytes are left untouched.
- R6: A byte other than 0x0A/0x0D that lies outside FIRST_CODE..LAST_CODE (defaults 0x20..0x7E) is replaced by DEFAULT_CODE (default 0x3F) before it is written.
- R7: A printable character that arrives while the column equals COLS first performs a newline, including a scroll on the last row. It is then written at column 0 of the resulting row, and the column becomes 1.
- R8: A clear request writes 0x20 to every character byte and ATTR_CLEAR (default 0x1F: background 1 in bits 7:4, foreground 15 in bits 3:0) to every attribute byte of the ROWS*COLS cells. Bytes beyond the screen are not written, and the cursor then returns to row 0, column 0.
- R9: A cursor load sets the column to min(load_col, COLS) and the row to min(load_row, ROWS).
- R10: A character is taken only on a clock where in_valid and in_ready are both high. in_ready is low while a scroll or clear runs, and also while clr_req or load_en is high. clr_req takes priority over load_en.
- R11: The scroll copy writes one byte per clock, in strictly increasing destination address order starting at 0.
- R12: After reset the cursor is at row 0, column 0, in_ready is high and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character byte offered |
| in_data | input | 8 | Character byte |
| in_ready | output | 1 | Block can take a character this clock |
| clr_req | input | 1 | Start a whole-screen clear |
| load_en | input | 1 | Load the cursor from load_row/load_col |
| load_row | input | LOAD_W (8) | Requested row, clamped |
| load_col | input | LOAD_W (8) | Requested column, clamped |
| cur_row | output | ROW_W (5) | Current cursor row |
| cur_col | output | COL_W (7) | Current cursor column |
| mem_re | output | 1 | Frame buffer read request |
| mem_raddr | output | ADDR_W (13) | Read byte address |
| mem_rdata | input | 8 | Read data, valid the clock after mem_re |
| mem_we | output | 1 | Frame buffer write strobe |
| mem_waddr | output | ADDR_W (13) | Write byte address |
| mem_wdata | output | 8 | Write data |

## Verification
The assertions rely on the memory returning read data exactly one clock after mem_re and never stalling. They also rely on clr_req and load_en being raised only while the block is idle, and on the host not loading a cursor position beyond the screen before it sends a printable character. The bench provides a one-cycle-latency byte memory. It raises its requests only at a falling edge after seeing in_ready high, and it uses out-of-range loads only to check clamping, reloading a valid position straight after.

// File: rtl/txtcon_pkg.sv
package txtcon_pkg;

   typedef enum logic [1:0] {
      K_PRINT = 2'd0,
      K_CR    = 2'd1,
      K_LF    = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      B_IDLE  = 2'd0,
      B_COPY  = 2'd1,
      B_BLANK = 2'd2,
      B_CLEAR = 2'd3
   } bulk_e;

   localparam logic [7:0] CODE_CR    = 8'h0D;
   localparam logic [7:0] CODE_LF    = 8'h0A;
   localparam logic [7:0] CODE_SPACE = 8'h20;

endpackage

// File: rtl/txtcon_classify.sv
module txtcon_classify
   import txtcon_pkg::*;
#(
   parameter logic [7:0] FIRST_CODE   = 8'h20,
   parameter logic [7:0] LAST_CODE    = 8'h7E,
   parameter logic [7:0] DEFAULT_CODE = 8'h3F,
   parameter int         SUBST_EN     = 1
) (
   input  logic [7:0] in_byte,
   output kind_e      kind,
   output logic [7:0] glyph
);

   always_comb begin
      if (in_byte == CODE_CR)      kind = K_CR;
      else if (in_byte == CODE_LF) kind = K_LF;
      else                         kind = K_PRINT;
   end

   generate
      if (SUBST_EN != 0) begin : g_subst
         logic out_of_range;
         assign out_of_range = (in_byte < FIRST_CODE) || (in_byte > LAST_CODE);
         assign glyph        = out_of_range ? DEFAULT_CODE : in_byte;
      end else begin : g_pass
         assign glyph = in_byte;
      end
   endgenerate

endmodule

// File: rtl/txtcon_bulk.sv
module txtcon_bulk
   import txtcon_pkg::*;
#(
   parameter int         COLS       = 80,
   parameter int         ROWS       = 25,
   parameter int         ADDR_W     = 13,
   parameter logic [7:0] ATTR_CLEAR = 8'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_copy,
   input  logic              start_clear,
   input  logic [7:0]        rdata,
   output logic              busy,
   output logic              last,
   output logic              re,
   output logic [ADDR_W-1:0] raddr,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [7:0]        wdata
);

   localparam int STRIDE       = 2 * COLS;
   localparam int COPY_BYTES   = (ROWS - 1) * STRIDE;
   localparam int SCREEN_BYTES = ROWS * STRIDE;

   bulk_e             st;
   logic [ADDR_W-1:0] cnt;
   logic              v1;
   logic [ADDR_W-1:0] a1;
   logic              rd_act;

   assign rd_act = (st == B_COPY) && (cnt < ADDR_W'(COPY_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= B_IDLE;
         cnt <= '0;
         v1  <= 1'b0;
         a1  <= '0;
      end else begin
         v1 <= rd_act;
         a1 <= cnt;
         case (st)
            B_IDLE: begin
               cnt <= '0;
               if (start_clear)     st <= B_CLEAR;
               else if (start_copy) st <= B_COPY;
            end
            B_COPY: begin
               if (rd_act) cnt <= cnt + ADDR_W'(1);
               if (!rd_act && !v1) begin
                  st  <= B_BLANK;
                  cnt <= '0;
               end
            end
            B_BLANK: begin
               if (cnt == ADDR_W'(COLS - 1)) st <= B_IDLE;
               else                          cnt <= cnt + ADDR_W'(1);
            end
            default: begin
               if (cnt == ADDR_W'(SCREEN_BYTES - 1)) st <= B_IDLE;
               else                                  cnt <= cnt + ADDR_W'(1);
            end
         endcase
      end
   end

   always_comb begin
      re    = rd_act;
      raddr = cnt + ADDR_W'(STRIDE);
      we    = 1'b0;
      waddr = '0;
      wdata = '0;
      case (st)
         B_COPY: begin
            we    = v1;
            waddr = a1;
            wdata = rdata;
         end
         B_BLANK: begin
            we    = 1'b1;
            waddr = ADDR_W'(COPY_BYTES) + {cnt[ADDR_W-2:0], 1'b0};
            wdata = CODE_SPACE;
         end
         B_CLEAR: begin
            we    = 1'b1;
            waddr = cnt;
            wdata = cnt[0] ? ATTR_CLEAR : CODE_SPACE;
         end
         default: ;
      endcase
   end

   assign busy = (st != B_IDLE);
   assign last = ((st == B_BLANK) && (cnt == ADDR_W'(COLS - 1))) ||
                 ((st == B_CLEAR) && (cnt == ADDR_W'(SCREEN_BYTES - 1)));

   assert_copy_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == B_COPY && v1 && $past(v1)) |-> (waddr == $past(waddr) + ADDR_W'(1)));

   assert_copy_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == B_COPY && we) |-> (waddr < ADDR_W'(COPY_BYTES)));

   assert_blank_chars_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == B_BLANK) |-> (we && !waddr[0] && waddr >= ADDR_W'(COPY_BYTES)));

   assert_clear_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == B_CLEAR) |-> (waddr < ADDR_W'(SCREEN_BYTES)));

endmodule

// File: rtl/txtcon_writer.sv
module txtcon_writer
   import txtcon_pkg::*;
#(
   parameter int         COLS         = 80,
   parameter int         CHAR_H       = 16,
   parameter int         SCAN_LINES   = 400,
   parameter logic [7:0] FIRST_CODE   = 8'h20,
   parameter logic [7:0] LAST_CODE    = 8'h7E,
   parameter logic [7:0] DEFAULT_CODE = 8'h3F,
   parameter logic [7:0] ATTR_CLEAR   = 8'h1F,
   parameter int         SUBST_EN     = 1,
   parameter int         LOAD_W       = 8,
   localparam int        ROWS         = SCAN_LINES / CHAR_H,
   localparam int        STRIDE       = 2 * COLS,
   localparam int        ROW_W        = $clog2(ROWS + 1),
   localparam int        COL_W        = $clog2(COLS + 1),
   localparam int        ADDR_W       = $clog2((ROWS + 1) * STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   input  logic              clr_req,
   input  logic              load_en,
   input  logic [LOAD_W-1:0] load_row,
   input  logic [LOAD_W-1:0] load_col,
   output logic [ROW_W-1:0]  cur_row,
   output logic [COL_W-1:0]  cur_col,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_raddr,
   input  logic [7:0]        mem_rdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata
);

   initial begin
      if (CHAR_H < 1 || ROWS < 2) $fatal(1, "txtcon_writer: fewer than two text rows");
      if (COLS < 2)               $fatal(1, "txtcon_writer: fewer than two columns");
      if (LOAD_W < ROW_W || LOAD_W < COL_W)
         $fatal(1, "txtcon_writer: load fields narrower than cursor");
   end

   kind_e             kind;
   logic [7:0]        glyph;
   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;
   logic              busy_q, op_clr, pend;
   logic [7:0]        pend_ch;
   logic              p_we;
   logic [ADDR_W-1:0] p_addr;
   logic [7:0]        p_data;
   logic              b_busy, b_last, b_we;
   logic [ADDR_W-1:0] b_waddr;
   logic [7:0]        b_wdata;
   logic              accept, row_lt_last, at_edge;
   logic              start_clear, start_copy;
   logic [ADDR_W-1:0] row_base, cell_addr, next_base;
   logic [ROW_W-1:0]  row_clamped;
   logic [COL_W-1:0]  col_clamped;

   txtcon_classify #(
      .FIRST_CODE  (FIRST_CODE),
      .LAST_CODE   (LAST_CODE),
      .DEFAULT_CODE(DEFAULT_CODE),
      .SUBST_EN    (SUBST_EN)
   ) classify_i (
      .in_byte(in_data),
      .kind   (kind),
      .glyph  (glyph)
   );

   txtcon_bulk #(
      .COLS      (COLS),
      .ROWS      (ROWS),
      .ADDR_W    (ADDR_W),
      .ATTR_CLEAR(ATTR_CLEAR)
   ) bulk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_copy (start_copy),
      .start_clear(start_clear),
      .rdata      (mem_rdata),
      .busy       (b_busy),
      .last       (b_last),
      .re         (mem_re),
      .raddr      (mem_raddr),
      .we         (b_we),
      .waddr      (b_waddr),
      .wdata      (b_wdata)
   );

   assign in_ready    = !busy_q && !clr_req && !load_en;
   assign accept      = in_valid && in_ready;
   assign row_lt_last = (row < ROW_W'(ROWS - 1));
   assign at_edge     = (col == COL_W'(COLS));
   assign start_clear = !busy_q && clr_req;
   assign start_copy  = accept && !row_lt_last &&
                        ((kind == K_LF) || (kind == K_PRINT && at_edge));

   assign row_base    = ADDR_W'(row) * ADDR_W'(STRIDE);
   assign cell_addr   = row_base + ADDR_W'({col, 1'b0});
   assign next_base   = row_base + ADDR_W'(STRIDE);
   assign row_clamped = (int'(load_row) > ROWS) ? ROW_W'(ROWS) : ROW_W'(load_row);
   assign col_clamped = (int'(load_col) > COLS) ? COL_W'(COLS) : COL_W'(load_col);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row     <= '0;
         col     <= '0;
         busy_q  <= 1'b0;
         op_clr  <= 1'b0;
         pend    <= 1'b0;
         pend_ch <= '0;
         p_we    <= 1'b0;
         p_addr  <= '0;
         p_data  <= '0;
      end else begin
         p_we <= 1'b0;
         if (!busy_q) begin
            if (clr_req) begin
               busy_q <= 1'b1;
               op_clr <= 1'b1;
            end else if (load_en) begin
               row <= row_clamped;
               col <= col_clamped;
            end else if (accept) begin
               case (kind)
                  K_CR: col <= '0;
                  K_LF: begin
                     col <= '0;
                     if (row_lt_last) row <= row + ROW_W'(1);
                     else begin
                        busy_q <= 1'b1;
                        op_clr <= 1'b0;
                     end
                  end
                  default: begin
                     if (!at_edge) begin
                        p_we   <= 1'b1;
                        p_addr <= cell_addr;
                        p_data <= glyph;
                        col    <= col + COL_W'(1);
                     end else if (row_lt_last) begin
                        p_we   <= 1'b1;
                        p_addr <= next_base;
                        p_data <= glyph;
                        row    <= row + ROW_W'(1);
                        col    <= COL_W'(1);
                     end else begin
                        col     <= '0;
                        pend    <= 1'b1;
                        pend_ch <= glyph;
                        busy_q  <= 1'b1;
                        op_clr  <= 1'b0;
                     end
                  end
               endcase
            end
         end else if (b_last) begin
            busy_q <= 1'b0;
            if (op_clr) begin
               row <= '0;
               col <= '0;
            end else if (pend) begin
               p_we   <= 1'b1;
               p_addr <= row_base;
               p_data <= pend_ch;
               col    <= COL_W'(1);
               pend   <= 1'b0;
            end
         end
      end
   end

   assign mem_we    = p_we || b_we;
   assign mem_waddr = p_we ? p_addr : b_waddr;
   assign mem_wdata = p_we ? p_data : b_wdata;
   assign cur_row   = row;
   assign cur_col   = col;

   assert_single_writer_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_we && b_we));

   assert_cr_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data == CODE_CR) |=> (cur_col == '0 && cur_row == $past(cur_row) && !mem_we));

   assert_lf_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data == CODE_LF && row_lt_last) |=>
         (cur_col == '0 && cur_row == $past(cur_row) + ROW_W'(1)));

   assert_glyph_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (SUBST_EN != 0 && accept && kind == K_PRINT && !at_edge) |=>
         (mem_we && ((mem_wdata >= FIRST_CODE && mem_wdata <= LAST_CODE) ||
                     mem_wdata == DEFAULT_CODE)));

   assert_col_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_col <= COL_W'(COLS));

   assert_clear_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(b_busy) && $past(op_clr)) |-> (cur_row == '0 && cur_col == '0));

   assert_row_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cur_row <= ROW_W'(ROWS));

   assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      b_busy |-> !in_ready);

endmodule

// File: tb/txtcon_writer_tb_top.sv
module txtcon_writer_tb_top;

   localparam int COLS   = 80;
   localparam int ROWS   = 25;
   localparam int STRIDE = 160;
   localparam int COPY   = (ROWS - 1) * STRIDE;
   localparam int SCREEN = ROWS * STRIDE;
   localparam int AW     = 13;
   localparam int MEMSZ  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_ready;
   logic          clr_req = 1'b0;
   logic          load_en = 1'b0;
   logic [7:0]    load_row = '0;
   logic [7:0]    load_col = '0;
   logic [4:0]    cur_row;
   logic [6:0]    cur_col;
   logic          mem_re;
   logic [AW-1:0] mem_raddr;
   logic [7:0]    mem_rdata;
   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [7:0]    mem_wdata;

   always #10 clk = ~clk;

   txtcon_writer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .clr_req(clr_req), .load_en(load_en),
      .load_row(load_row), .load_col(load_col), .cur_row(cur_row),
      .cur_col(cur_col), .mem_re(mem_re), .mem_raddr(mem_raddr),
      .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   // byte memory with one-clock read latency
   logic [7:0] dmem [0:MEMSZ-1];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEMSZ; i++) dmem[i] <= pat(i);
      end else begin
         if (mem_we) dmem[mem_waddr] <= mem_wdata;
         if (mem_re) mem_rdata <= dmem[mem_raddr];
      end
   end

   // behavioural reference
   logic [7:0] ref_mem [0:MEMSZ-1];
   int mrow, mcol;
   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   bit scr_mon = 0;
   int exp_next, ordbad;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic m_newline();
      mcol = 0;
      if (mrow < ROWS - 1) mrow++;
      else begin
         for (int a = 0; a < COPY; a++) ref_mem[a] = ref_mem[a + STRIDE];
         for (int k = 0; k < COLS; k++) ref_mem[COPY + 2 * k] = 8'h20;
      end
   endtask

   task automatic m_char(input logic [7:0] c);
      logic [7:0] g;
      if (c == 8'h0D) mcol = 0;
      else if (c == 8'h0A) m_newline();
      else begin
         g = (c < 8'h20 || c > 8'h7E) ? 8'h3F : c;
         if (mcol == COLS) m_newline();
         ref_mem[mrow * STRIDE + mcol * 2] = g;
         mcol++;
      end
   endtask

   // per-clock cursor comparison whenever the block is accepting
   always @(negedge clk) begin
      if (cmp_on && in_ready) begin
         check(int'(cur_row) == mrow && int'(cur_col) == mcol, "R3", "cursor track",
               int'(cur_row) * 256 + int'(cur_col), mrow * 256 + mcol);
      end
      if (scr_mon && mem_we && int'(mem_waddr) < COPY) begin
         if (int'(mem_waddr) != exp_next) ordbad++;
         exp_next++;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] c);
      @(negedge clk);
      in_data  = c;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      m_char(c);
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send(s[i]);
   endtask

   task automatic load(input int r, input int c);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      load_en  = 1'b1;
      load_row = 8'(r);
      load_col = 8'(c);
      @(posedge clk);
      #1;
      load_en = 1'b0;
      mrow = (r > ROWS) ? ROWS : r;
      mcol = (c > COLS) ? COLS : c;
   endtask

   task automatic mem_compare(input string req);
      int bad = 0;
      int first = -1;
      for (int a = 0; a < MEMSZ; a++) begin
         if (dmem[a] !== ref_mem[a]) begin
            bad++;
            if (first < 0) first = a;
         end
      end
      if (first < 0) check(1'b1, req, "memory image", 0, 0);
      else check(1'b0, req, $sformatf("memory image at %0d", first),
                 int'(dmem[first]), int'(ref_mem[first]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int busy_cyc;
      for (int a = 0; a < MEMSZ; a++) ref_mem[a] = pat(a);
      mrow = 0;
      mcol = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(in_ready == 1'b1, "R12", "ready after reset", int'(in_ready), 1);
      check(cur_row == 0 && cur_col == 0, "R12", "cursor after reset",
            int'(cur_row) * 256 + int'(cur_col), 0);
      check(mem_we == 1'b0, "R12", "no write after reset", int'(mem_we), 0);
      cmp_on = 1;

      // R1 placement
      send_str("AB");
      wait_idle();
      check(dmem[0] == 8'h41, "R1", "char at cell 0", int'(dmem[0]), 'h41);
      check(dmem[2] == 8'h42, "R1", "char at cell 1", int'(dmem[2]), 'h42);
      check(dmem[1] == pat(1), "R1", "attribute untouched", int'(dmem[1]), int'(pat(1)));

      // R2 carriage return
      send_str("xy");
      send(8'h0D);
      @(negedge clk);
      check(cur_col == 0 && cur_row == 0, "R2", "cursor after CR",
            int'(cur_row) * 256 + int'(cur_col), 0);
      send("z");
      wait_idle();
      check(dmem[0] == 8'h7A, "R2", "overwrite at column 0", int'(dmem[0]), 'h7A);
      mem_compare("R2");

      // R9 cursor load and clamp
      load(3, 5);
      @(negedge clk);
      check(cur_row == 3 && cur_col == 5, "R9", "load in range",
            int'(cur_row) * 256 + int'(cur_col), 3 * 256 + 5);
      send("Z");
      wait_idle();
      check(dmem[3 * STRIDE + 10] == 8'h5A, "R1", "char at loaded cursor",
            int'(dmem[3 * STRIDE + 10]), 'h5A);
      load(200, 200);
      @(negedge clk);
      check(cur_row == 25 && cur_col == 80, "R9", "load clamped",
            int'(cur_row) * 256 + int'(cur_col), 25 * 256 + 80);

      // R10 ready held low by a load request
      @(negedge clk);
      load_en = 1'b1;
      #1;
      check(in_ready == 1'b0, "R10", "ready during load request", int'(in_ready), 0);
      @(negedge clk);
      load_en = 1'b0;
      @(negedge clk);
      clr_req = 1'b1;
      #1;
      check(in_ready == 1'b0, "R10", "ready during clear request", int'(in_ready), 0);
      clr_req = 1'b0;

      // R7 wrap before the last column is exceeded
      load(2, 79);
      send_str("ab");
      wait_idle();
      check(dmem[2 * STRIDE + 158] == 8'h61, "R7", "last column char",
            int'(dmem[2 * STRIDE + 158]), 'h61);
      check(dmem[3 * STRIDE] == 8'h62, "R7", "wrapped char", int'(dmem[3 * STRIDE]), 'h62);
      check(cur_row == 3 && cur_col == 1, "R7", "cursor after wrap",
            int'(cur_row) * 256 + int'(cur_col), 3 * 256 + 1);

      // R6 substitution
      load(5, 0);
      send(8'h01);
      send(8'h7F);
      send(8'h7E);
      send(8'h20);
      wait_idle();
      check(dmem[5 * STRIDE] == 8'h3F, "R6", "low code replaced", int'(dmem[5 * STRIDE]), 'h3F);
      check(dmem[5 * STRIDE + 2] == 8'h3F, "R6", "high code replaced",
            int'(dmem[5 * STRIDE + 2]), 'h3F);
      check(dmem[5 * STRIDE + 4] == 8'h7E, "R6", "last code kept",
            int'(dmem[5 * STRIDE + 4]), 'h7E);
      check(dmem[5 * STRIDE + 6] == 8'h20, "R6", "first code kept",
            int'(dmem[5 * STRIDE + 6]), 'h20);

      // R3 newline walk down to the last row
      load(0, 7);
      for (int i = 0; i < ROWS - 1; i++) send(8'h0A);
      @(negedge clk);
      check(cur_row == 24 && cur_col == 0, "R3", "row after 24 newlines",
            int'(cur_row) * 256 + int'(cur_col), 24 * 256);
      mem_compare("R3");

      // R4 R5 R11 R10 scroll
      load(24, 0);
      send_str("LAST");
      wait_idle();
      exp_next = 0;
      ordbad   = 0;
      scr_mon  = 1;
      send(8'h0A);
      busy_cyc = 0;
      @(negedge clk);
      while (!in_ready) begin
         busy_cyc++;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
      scr_mon = 0;
      check(busy_cyc >= COPY, "R10", "ready low through scroll", busy_cyc, COPY);
      check(ordbad == 0 && exp_next == COPY, "R11", "copy order and count",
            ordbad * 65536 + exp_next, COPY);
      check(dmem[23 * STRIDE] == 8'h4C, "R4", "row moved up", int'(dmem[23 * STRIDE]), 'h4C);
      check(dmem[23 * STRIDE + 1] == pat(24 * STRIDE + 1), "R4", "attribute moved up",
            int'(dmem[23 * STRIDE + 1]), int'(pat(24 * STRIDE + 1)));
      check(dmem[24 * STRIDE] == 8'h20, "R5", "bottom char blanked",
            int'(dmem[24 * STRIDE]), 'h20);
      check(dmem[24 * STRIDE + 1] == pat(24 * STRIDE + 1), "R5", "bottom attribute kept",
            int'(dmem[24 * STRIDE + 1]), int'(pat(24 * STRIDE + 1)));
      check(cur_row == 24 && cur_col == 0, "R4", "cursor after scroll",
            int'(cur_row) * 256 + int'(cur_col), 24 * 256);
      mem_compare("R4");

      // R7 wrap on the last row: scroll then place
      load(24, 80);
      send("Q");
      wait_idle();
      check(dmem[24 * STRIDE] == 8'h51, "R7", "char after scroll wrap",
            int'(dmem[24 * STRIDE]), 'h51);
      check(cur_row == 24 && cur_col == 1, "R7", "cursor after scroll wrap",
            int'(cur_row) * 256 + int'(cur_col), 24 * 256 + 1);
      mem_compare("R5");

      // R8 clear
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      clr_req = 1'b1;
      @(posedge clk);
      #1;
      clr_req = 1'b0;
      for (int a = 0; a < SCREEN; a++) ref_mem[a] = a[0] ? 8'h1F : 8'h20;
      mrow = 0;
      mcol = 0;
      wait_idle();
      check(cur_row == 0 && cur_col == 0, "R8", "cursor after clear",
            int'(cur_row) * 256 + int'(cur_col), 0);
      check(dmem[0] == 8'h20 && dmem[1] == 8'h1F, "R8", "first cell",
            int'(dmem[0]) * 256 + int'(dmem[1]), 'h201F);
      check(dmem[SCREEN - 1] == 8'h1F, "R8", "last attribute",
            int'(dmem[SCREEN - 1]), 'h1F);
      check(dmem[SCREEN] == pat(SCREEN), "R8", "beyond screen untouched",
            int'(dmem[SCREEN]), int'(pat(SCREEN)));
      mem_compare("R8");

      send_str("hi");
      send(8'h0D);
      send("!");
      wait_idle();
      check(dmem[0] == 8'h21 && dmem[2] == 8'h69, "R2", "CR after clear",
            int'(dmem[0]) * 256 + int'(dmem[2]), 'h2169);
      mem_compare("R1");

      cmp_on = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule